// File: doc/BRIEF.md
# NAND Command Register with Status and Identification Responder

This block models the device side of the command register of a NAND-style flash. The host writes command and address bytes with a write strobe, and the command-latch and address-latch enables tell the two apart. The block keeps track of one output mode: array data, single status, per-plane status, waiting for an identification address, or identification. On every read cycle it returns the byte that belongs to the current mode.

The flash array and the real program and erase engines are outside this block. The engine's busy flag, the write-protect state and one pass/fail flag per plane arrive as plain inputs. Array data comes in on `arr_data_i` and is passed through while the block is in array mode. Status bytes are built from the live inputs, so a poller sees the ready bit change without opening a new read cycle. The I/O pad is modelled as a data output plus an output enable. The pad itself drives high impedance whenever the enable is low.

All inputs are sampled on `clk_i`. A write strobe is a cycle in which `we_i` is high. A read cycle lasts for as long as `ce_i` and `re_i` are both high, and it ends in the first cycle in which they are not both high.

Top module: `nand_cmd_resp`

## Requirements
- R1: `io_oe_o` is 1 exactly when `ce_i` and `re_i` are both 1. While it is 0, `io_o` is 00h.
- R2: A command byte is taken from `io_i` on a clock edge where `we_i`, `ce_i` and `cle_i` are 1 and `ale_i` is 0. An address byte is taken on a clock edge where `we_i`, `ce_i` and `ale_i` are 1 and `cle_i` is 0. Any other combination has no effect.
- R3: After command 70h, each read returns a single-status byte. Bit 7 is 1 when not write-protected (`wp_i`=0). Bit 6 is 1 when ready (`busy_i`=0). Bit 0 is 1 when any plane flag is set. Bits 5 to 1 are 0.
- R4: After command 71h, each read returns a per-plane status byte. Bits 7 and 6 mean the same as in R3. Bit 0 is the OR of all plane flags. Bits 1 to 4 carry `plane_fail_i[0]` to `plane_fail_i[3]`. Bit 5 is 0.
- R5: While `busy_i` is 1, every pass/fail bit of both status bytes reads 0.
- R6: A status byte follows `busy_i`, `wp_i` and `plane_fail_i` in the same cycle, even while a read cycle is held open.
- R7: The mode persists over any number of read cycles until a new command is written.
- R8: After reset, and after command 00h or 50h, reads return `arr_data_i`.
- R9: Command 90h followed by address 00h selects identification. Successive read cycles then return ECh, 79h, A5h and C0h. The byte advances when a read cycle ends.
- R10: Once the fourth identification byte has been read, further reads return 00h until the next command.
- R11: A command byte other than 00h, 50h, 70h, 71h or 90h leaves the mode unchanged.
- R12: After 90h and before address 00h arrives, reads return 00h. A nonzero address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable, active high |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| we_i | input | 1 | Write strobe (one cycle per byte) |
| re_i | input | 1 | Read enable, active high |
| io_i | input | 8 | Command or address byte from host |
| io_o | output | 8 | Read data to host |
| io_oe_o | output | 1 | Pad output enable |
| busy_i | input | 1 | Internal operation in progress |
| wp_i | input | 1 | Write protection active |
| plane_fail_i | input | N_PLANES | Per-plane failure flags of last operation |
| arr_data_i | input | 8 | Array data for array-read mode |

## Verification
A wrong mode register shows up on the first read after the bad command or address. The host then sees array data, the wrong status layout, or identification bytes where another mode was expected. A fault in the identification pointer shows up in the read cycle after the one where it happened, as a repeated or skipped byte, or as a nonzero byte after the fourth. A fault in masking or field placement shows up in the same cycle that `busy_i` or a plane flag changes, because status is combinational from those inputs. The bench's reference model is compared with the bus on every clock, so each of these faults is caught within one cycle of becoming visible.

// File: rtl/nand_resp_pkg.sv
package nand_resp_pkg;

  typedef enum logic [2:0] {
    MODE_ARRAY,
    MODE_STAT,
    MODE_MSTAT,
    MODE_IDWAIT,
    MODE_ID
  } mode_e;

  localparam logic [7:0] CMD_READ_A = 8'h00;
  localparam logic [7:0] CMD_READ_B = 8'h50;
  localparam logic [7:0] CMD_STAT   = 8'h70;
  localparam logic [7:0] CMD_MSTAT  = 8'h71;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] ADDR_IDENT = 8'h00;

  localparam int unsigned ID_LEN = 4;

  function automatic logic [7:0] id_byte(input int unsigned idx);
    case (idx)
      0:       id_byte = 8'hEC;
      1:       id_byte = 8'h79;
      2:       id_byte = 8'hA5;
      3:       id_byte = 8'hC0;
      default: id_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
  import nand_resp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_i,
  input  logic [7:0] io_i,
  output mode_e      mode_o,
  output logic       id_start_o
);

  logic  cmd_we, addr_we;
  mode_e mode_q, mode_d;

  assign cmd_we  = we_i & ce_i & cle_i & ~ale_i;
  assign addr_we = we_i & ce_i & ale_i & ~cle_i;

  always_comb begin
    mode_d     = mode_q;
    id_start_o = 1'b0;
    if (cmd_we) begin
      case (io_i)
        CMD_READ_A, CMD_READ_B: mode_d = MODE_ARRAY;
        CMD_STAT:               mode_d = MODE_STAT;
        CMD_MSTAT:              mode_d = MODE_MSTAT;
        CMD_IDENT:              mode_d = MODE_IDWAIT;
        default:                mode_d = mode_q;  // unknown opcode: hold
      endcase
    end else if (addr_we && mode_q == MODE_IDWAIT && io_i == ADDR_IDENT) begin
      mode_d     = MODE_ID;
      id_start_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_ARRAY;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/nand_id_seq.sv
module nand_id_seq
  import nand_resp_pkg::*;
#(
  parameter int unsigned LEN = ID_LEN
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       active_i,
  input  logic       rd_end_i,
  output logic [7:0] byte_o
);

  localparam int unsigned PW = $clog2(LEN + 1);

  logic [PW-1:0] ptr_q;
  logic          more;

  assign more = ptr_q < PW'(LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ptr_q <= '0;
    else if (start_i)                      ptr_q <= '0;
    else if (active_i && rd_end_i && more) ptr_q <= ptr_q + 1'b1;
  end

  assign byte_o = more ? id_byte(int'(ptr_q)) : 8'h00;

endmodule

// File: rtl/nand_status_fmt.sv
module nand_status_fmt #(
  parameter int unsigned N_PLANES = 4
) (
  input  logic                busy_i,
  input  logic                wp_i,
  input  logic [N_PLANES-1:0] plane_fail_i,
  input  logic                multi_i,
  output logic [7:0]          byte_o
);

  logic       ready;
  logic [4:0] plane_bits;

  assign ready = ~busy_i;

  generate
    for (genvar p = 0; p < 5; p++) begin : g_plane
      if (p < N_PLANES) begin : g_used
        assign plane_bits[p] = multi_i & ready & plane_fail_i[p];
      end else begin : g_none
        assign plane_bits[p] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    byte_o      = 8'h00;
    byte_o[7]   = ~wp_i;
    byte_o[6]   = ready;
    byte_o[0]   = ready & (|plane_fail_i);
    byte_o[5:1] = plane_bits;
  end

endmodule

// File: rtl/nand_cmd_resp.sv
module nand_cmd_resp
  import nand_resp_pkg::*;
#(
  parameter int unsigned N_PLANES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ce_i,
  input  logic                cle_i,
  input  logic                ale_i,
  input  logic                we_i,
  input  logic                re_i,
  input  logic [7:0]          io_i,
  output logic [7:0]          io_o,
  output logic                io_oe_o,
  input  logic                busy_i,
  input  logic                wp_i,
  input  logic [N_PLANES-1:0] plane_fail_i,
  input  logic [7:0]          arr_data_i
);

  if (N_PLANES < 1 || N_PLANES > 4) begin : g_bad_planes
    $error("N_PLANES must be 1..4");
  end

  mode_e      mode_q;
  logic       id_start, rd_act, rd_q, rd_end;
  logic [7:0] stat_byte, id_byte_w, sel_byte;

  nand_cmd_decode u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .cle_i(cle_i),
    .ale_i(ale_i), .we_i(we_i), .io_i(io_i),
    .mode_o(mode_q), .id_start_o(id_start)
  );

  assign rd_act = ce_i & re_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_act;
  end

  assign rd_end = rd_q & ~rd_act;

  nand_id_seq #(.LEN(ID_LEN)) u_id (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(id_start),
    .active_i(mode_q == MODE_ID), .rd_end_i(rd_end), .byte_o(id_byte_w)
  );

  nand_status_fmt #(.N_PLANES(N_PLANES)) u_stat (
    .busy_i(busy_i), .wp_i(wp_i), .plane_fail_i(plane_fail_i),
    .multi_i(mode_q == MODE_MSTAT), .byte_o(stat_byte)
  );

  always_comb begin
    case (mode_q)
      MODE_ARRAY:            sel_byte = arr_data_i;
      MODE_STAT, MODE_MSTAT: sel_byte = stat_byte;
      MODE_ID:               sel_byte = id_byte_w;
      default:               sel_byte = 8'h00;
    endcase
  end

  assign io_oe_o = rd_act;
  assign io_o    = rd_act ? sel_byte : 8'h00;

endmodule

// File: rtl/nand_cmd_resp_chk.sv
module nand_cmd_resp_chk
  import nand_resp_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_i,
  input logic       cle_i,
  input logic       ale_i,
  input logic       we_i,
  input logic       re_i,
  input logic [7:0] io_i,
  input logic [7:0] io_o,
  input logic       io_oe_o,
  input logic       busy_i,
  input mode_e      mode_i
);

  logic cmd_we;
  logic known;
  assign cmd_we = we_i & ce_i & cle_i & ~ale_i;
  assign known  = io_i inside {CMD_READ_A, CMD_READ_B, CMD_STAT, CMD_MSTAT, CMD_IDENT};

  AST_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_i && re_i) |-> (!io_oe_o && io_o == 8'h00)); // R1

  AST_STAT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && io_i == CMD_STAT) |=> mode_i == MODE_STAT); // R3

  AST_BUSY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && io_oe_o && (mode_i == MODE_STAT || mode_i == MODE_MSTAT))
      |-> (io_o[6] == 1'b0 && io_o[5:0] == 6'h00)); // R5

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_we |=> (mode_i == $past(mode_i) ||
                 ($past(mode_i) == MODE_IDWAIT && mode_i == MODE_ID))); // R7

  AST_ARRAY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && (io_i == CMD_READ_A || io_i == CMD_READ_B)) |=> mode_i == MODE_ARRAY); // R8

  AST_UNKNOWN_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && !known) |=> $stable(mode_i)); // R11

endmodule

bind nand_cmd_resp nand_cmd_resp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .cle_i(cle_i), .ale_i(ale_i),
  .we_i(we_i), .re_i(re_i), .io_i(io_i), .io_o(io_o), .io_oe_o(io_oe_o),
  .busy_i(busy_i), .mode_i(mode_q)
);

// File: tb/nand_cmd_resp_test.sv
module nand_cmd_resp_test;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 0, cle = 0, ale = 0, we = 0, re = 0;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic       oe;
  logic       busy = 0, wp = 0;
  logic [3:0] pfail = 0;
  logic [7:0] arr = 8'h3C;

  int total = 0, bad = 0, cycles = 0;

  // reference model state: 0 array,1 stat,2 mstat,3 idwait,4 id
  int m_mode = 0, m_id = 0;
  bit m_rdq = 0;

  nand_cmd_resp uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .cle_i(cle), .ale_i(ale),
    .we_i(we), .re_i(re), .io_i(din), .io_o(dout), .io_oe_o(oe),
    .busy_i(busy), .wp_i(wp), .plane_fail_i(pfail), .arr_data_i(arr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_id = 0; m_rdq = 0;
    end else begin
      bit rd;
      rd = ce && re;
      if (m_rdq && !rd && m_mode == 4 && m_id < 4) m_id++;
      if (we && ce && cle && !ale) begin
        case (din)
          8'h00, 8'h50: m_mode = 0;
          8'h70:        m_mode = 1;
          8'h71:        m_mode = 2;
          8'h90:        m_mode = 3;
          default: ;
        endcase
      end else if (we && ce && ale && !cle && m_mode == 3 && din == 8'h00) begin
        m_mode = 4; m_id = 0;
      end
      m_rdq = rd;
    end
  end

  function automatic logic [7:0] exp_byte();
    logic [7:0] b;
    bit rdy;
    rdy = !busy;
    b = 8'h00;
    if (!(ce && re)) return 8'h00;
    case (m_mode)
      0: b = arr;
      1: b = {~wp, rdy, 5'b0, rdy & (|pfail)};
      2: b = {~wp, rdy, 1'b0, rdy ? pfail : 4'b0, rdy & (|pfail)};
      4: case (m_id)
           0: b = 8'hEC; 1: b = 8'h79; 2: b = 8'hA5; 3: b = 8'hC0;
           default: b = 8'h00;
         endcase
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic string mode_tag();
    if (!(ce && re)) return "R1";
    case (m_mode)
      0: return "R8";
      1: return "R3";
      2: return "R4";
      3: return "R12";
      default: return (m_id < 4) ? "R9" : "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got oe=%0b io=%02h, expected oe=%0b io=%02h",
               tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  // per-clock comparison against the model
  task automatic cmp();
    check(mode_tag(), {oe, dout}, {ce && re, exp_byte()});
  endtask

  task automatic cyc(input bit c, input bit cl, input bit al, input bit w, input bit r,
                     input logic [7:0] d);
    @(negedge clk);
    ce = c; cle = cl; ale = al; we = w; re = r; din = d;
    #1 cmp();
  endtask

  task automatic wr_cmd(input logic [7:0] c);
    cyc(1, 1, 0, 1, 0, c);
    cyc(1, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic wr_addr(input logic [7:0] a);
    cyc(1, 0, 1, 1, 0, a);
    cyc(1, 0, 0, 0, 0, 8'h00);
  endtask

  // one read cycle: read enable high for two clocks, then released
  task automatic rd_cycle(input string tag, input logic [7:0] exp);
    cyc(1, 0, 0, 0, 1, 8'h00);
    check(tag, {oe, dout}, {1'b1, exp});
    cyc(1, 0, 0, 0, 1, 8'h00);
    cyc(1, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog: got cycles=%0d, expected < 100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    #1;
    check("R1", {oe, dout}, 9'h000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state is array read
    rd_cycle("R8", 8'h3C);
    arr = 8'h5A;
    rd_cycle("R8", 8'h5A);

    // R2: command without cle or ce is ignored
    cyc(1, 0, 0, 1, 0, 8'h70);
    cyc(0, 1, 0, 1, 0, 8'h70);
    cyc(1, 1, 1, 1, 0, 8'h70);
    rd_cycle("R2", 8'h5A);

    // R3: single status
    pfail = 4'b0010;
    wr_cmd(8'h70);
    rd_cycle("R3", 8'hC1);
    pfail = 4'b0000; wp = 1;
    rd_cycle("R3", 8'h40);
    wp = 0;

    // R5: busy masks pass/fail
    busy = 1; pfail = 4'b1111;
    rd_cycle("R5", 8'h80);

    // R6: live update inside one held read cycle
    cyc(1, 0, 0, 0, 1, 8'h00);
    check("R6", {oe, dout}, 9'h180);
    busy = 0;
    #1 check("R6", {oe, dout}, 9'h1C1);
    cyc(1, 0, 0, 0, 1, 8'h00);
    cyc(1, 0, 0, 0, 0, 8'h00);

    // R7: mode persists across many reads
    pfail = 4'b0000;
    for (int i = 0; i < 6; i++) rd_cycle("R7", 8'hC0);

    // R11: unrecognised commands keep status mode
    wr_cmd(8'h33);
    wr_cmd(8'hFF);
    rd_cycle("R11", 8'hC0);

    // R4: per-plane status
    pfail = 4'b1010;
    wr_cmd(8'h71);
    rd_cycle("R4", 8'hD5);
    pfail = 4'b0001;
    rd_cycle("R4", 8'hC3);
    busy = 1;
    rd_cycle("R5", 8'h80);
    busy = 0; pfail = 4'b0000;

    // R8: 50h returns to array
    wr_cmd(8'h50);
    arr = 8'hA7;
    rd_cycle("R8", 8'hA7);

    // R12: wait for address; nonzero address ignored
    wr_cmd(8'h90);
    rd_cycle("R12", 8'h00);
    wr_addr(8'h01);
    rd_cycle("R12", 8'h00);
    wr_addr(8'h00);

    // R9: identification sequence
    rd_cycle("R9", 8'hEC);
    rd_cycle("R9", 8'h79);
    rd_cycle("R9", 8'hA5);
    rd_cycle("R9", 8'hC0);
    // R10: beyond the sequence
    rd_cycle("R10", 8'h00);
    rd_cycle("R10", 8'h00);

    // R9: restart from first byte after new 90h/00h
    wr_cmd(8'h90);
    wr_addr(8'h00);
    rd_cycle("R9", 8'hEC);

    // R8: 00h leaves identification
    wr_cmd(8'h00);
    rd_cycle("R8", 8'hA7);

    // R1: idle bus with ce low but re high
    cyc(0, 0, 0, 0, 1, 8'h00);
    check("R1", {oe, dout}, 9'h000);
    cyc(0, 0, 0, 0, 0, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule